// File: doc/BRIEF.md
# Five-Level Third-Order Noise-Shaping Modulator

This block turns an 18-bit two's-complement audio stream, already interpolated to eight times the sample rate, into a five-level stream at 48 or 64 times the sample rate. It is meant to drive a five-level converter. Each incoming word is latched on an input strobe and then fed to the noise-shaping loop for six or eight consecutive clocks, chosen by a rate select. So one modulator output leaves per clock while a word is being held. Each output is a level code from 0 to 4 with its own strobe.

The loop has three delayed integrators in a chain. Their outputs are weighted by 1, 1/2 and 1/8, added to the held input and quantized to five evenly spaced levels. The chosen level is subtracted from the input at the first integrator. These weights place all loop poles inside the unit circle, with a peak noise gain of about 1.64. A five-level quantizer handles that peak with a wide margin for inputs up to roughly four tenths of full scale. The integrators carry guard bits and saturate.

A force-to-midscale input pins every output at the centre code and clears the loop state. This gives the forced bipolar-zero condition, and afterwards the loop restarts cleanly.

Top module: `dsm5_mod`

## Requirements
- R1: During and right after synchronous reset, `level_valid` is 0 and `level_code` is 2.
- R2: Each `sample_valid` pulse produces exactly 8 output strobes when `rate_sel` is 0, or 6 when `rate_sel` is 1. The first strobe is on the clock after the pulse, and there are none while idle.
- R3: Every output code lies in 0..4. Code k stands for the value (k-2)*2^16 on the 18-bit input scale, so code 0 is -2^17, code 2 is zero and code 4 is +2^17.
- R4: A zero input from a cleared state gives code 2 on every output.
- R5: For a steady input x, the sum of the output values (code-2)*2^16 over a run differs from x times the output count by no more than 2^19.
- R6: From a cleared state, input -131072 gives code 0 on every output, and input +131071 gives code 4 for at least the first 64 outputs. The integrators clamp at their limits and never wrap.
- R7: While `force_mid` is 1, every output is code 2 and the integrators are cleared. After release, a zero input gives code 2 on every output.
- R8: If input words arrive every 8 clocks (`rate_sel`=0) or every 6 clocks (`rate_sel`=1), the output strobe stays high on every clock from the first output to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 18 | Signed input word |
| sample_valid | input | 1 | Latches `sample_in` and starts its hold window |
| rate_sel | input | 1 | 0: hold for 8 clocks (64x), 1: hold for 6 clocks (48x) |
| force_mid | input | 1 | Forces code 2 and clears the loop |
| level_code | output | 3 | Quantized level, 0..4 |
| level_valid | output | 1 | Output strobe |

## Verification
The bench targets the hold count at each rate. A miscounted window would add or drop strobes, and at a steady word rate it would leave gaps or overlap. The two full-scale extremes are driven from a cleared state. A misplaced threshold or a wrong feedback level would leave code 0 at negative full scale, and a wrong sign would stop code 4 from holding at positive full scale. Steady inputs of both signs check long-run tracking, which fails if the feedback scale or the weights are wrong. Zero input after a forced period shows whether the integrators were cleared: stale state would push codes away from 2.

// File: rtl/dsm5_pkg.sv
package dsm5_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned NUM_LEVELS = 5;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t MID_CODE = code_t'(2);
  localparam code_t TOP_CODE = code_t'(NUM_LEVELS - 1);
endpackage

// File: rtl/dsm5_sat_integ.sv
module dsm5_sat_integ #(
  parameter int unsigned W = 22
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] q
);
  localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] sum;
  logic signed [W-1:0] nxt;

  assign sum = {q[W-1], q} + {din[W-1], din};

  always_comb begin
    if (sum[W] != sum[W-1]) nxt = sum[W] ? MIN_V : MAX_V;
    else                    nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= nxt;
  end
endmodule

// File: rtl/dsm5_quant.sv
module dsm5_quant
  import dsm5_pkg::*;
#(
  parameter int unsigned VW     = 24,
  parameter int unsigned FW     = 22,
  parameter int unsigned DATA_W = 18
) (
  input  logic signed [VW-1:0] v,
  output code_t                code,
  output logic signed [FW-1:0] fb
);
  localparam int STEP = 1 << (DATA_W - 2);
  localparam logic signed [VW-1:0] TH_HI  = VW'((3 * STEP) / 2);
  localparam logic signed [VW-1:0] TH_MHI = VW'(STEP / 2);
  localparam logic signed [VW-1:0] TH_MLO = VW'(-(STEP / 2));
  localparam logic signed [VW-1:0] TH_LO  = VW'(-((3 * STEP) / 2));

  always_comb begin
    if (v >= TH_HI)       code = code_t'(4);
    else if (v >= TH_MHI) code = code_t'(3);
    else if (v > TH_MLO)  code = code_t'(2);
    else if (v > TH_LO)   code = code_t'(1);
    else                  code = code_t'(0);
  end

  always_comb begin
    case (code)
      code_t'(0): fb = FW'(-2 * STEP);
      code_t'(1): fb = FW'(-STEP);
      code_t'(3): fb = FW'(STEP);
      code_t'(4): fb = FW'(2 * STEP);
      default:    fb = '0;
    endcase
  end
endmodule

// File: rtl/dsm5_pacer.sv
module dsm5_pacer #(
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned HOLD_SLOW = 8,
  parameter int unsigned HOLD_FAST = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_valid,
  input  logic signed [DATA_W-1:0] sample_in,
  input  logic                     rate_sel,
  output logic signed [DATA_W-1:0] x_q,
  output logic                     step
);
  localparam int unsigned HOLD_MAX = (HOLD_SLOW > HOLD_FAST) ? HOLD_SLOW : HOLD_FAST;
  localparam int unsigned CNT_W = $clog2(HOLD_MAX + 1);

  logic [CNT_W-1:0] remain;

  assign step = (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      x_q    <= '0;
    end else if (sample_valid) begin
      remain <= rate_sel ? CNT_W'(HOLD_FAST) : CNT_W'(HOLD_SLOW);
      x_q    <= sample_in;
    end else if (step) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/dsm5_mod.sv
module dsm5_mod
  import dsm5_pkg::*;
#(
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned GUARD_W   = 4,
  parameter int unsigned HOLD_SLOW = 8,
  parameter int unsigned HOLD_FAST = 6,
  parameter int unsigned SH_I1     = 0,
  parameter int unsigned SH_I2     = 1,
  parameter int unsigned SH_I3     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              sample_valid,
  input  logic              rate_sel,
  input  logic              force_mid,
  output logic [CODE_W-1:0] level_code,
  output logic              level_valid
);
  localparam int unsigned ACC_W = DATA_W + GUARD_W;
  localparam int unsigned VW = ACC_W + 2;
  localparam int unsigned NUM_INTEG = 3;
  localparam int unsigned SHIFTS [NUM_INTEG] = '{SH_I1, SH_I2, SH_I3};

  logic signed [DATA_W-1:0] x_q;
  logic                     step;
  logic signed [ACC_W-1:0]  x_acc;
  logic signed [ACC_W-1:0]  fb_acc;
  logic signed [ACC_W-1:0]  err_acc;
  logic signed [ACC_W-1:0]  stage_in [NUM_INTEG];
  logic signed [ACC_W-1:0]  intg_q   [NUM_INTEG];
  logic signed [VW-1:0]     loop_sum;
  code_t                    q_code;

  dsm5_pacer #(
    .DATA_W(DATA_W), .HOLD_SLOW(HOLD_SLOW), .HOLD_FAST(HOLD_FAST)
  ) u_pacer (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .sample_in(sample_in), .rate_sel(rate_sel),
    .x_q(x_q), .step(step)
  );

  assign x_acc   = {{GUARD_W{x_q[DATA_W-1]}}, x_q};
  assign err_acc = x_acc - fb_acc;

  for (genvar k = 0; k < NUM_INTEG; k++) begin : g_integ
    if (k == 0) begin : g_first
      assign stage_in[k] = err_acc;
    end else begin : g_chain
      assign stage_in[k] = intg_q[k-1];
    end
    dsm5_sat_integ #(.W(ACC_W)) u_int (
      .clk(clk), .rst(rst), .clr(force_mid), .en(step),
      .din(stage_in[k]), .q(intg_q[k])
    );
  end

  always_comb begin
    logic signed [ACC_W-1:0] shifted;
    loop_sum = {{(VW-ACC_W){x_acc[ACC_W-1]}}, x_acc};
    for (int k = 0; k < NUM_INTEG; k++) begin
      shifted  = intg_q[k] >>> SHIFTS[k];
      loop_sum = loop_sum + {{(VW-ACC_W){shifted[ACC_W-1]}}, shifted};
    end
  end

  dsm5_quant #(.VW(VW), .FW(ACC_W), .DATA_W(DATA_W)) u_quant (
    .v(loop_sum), .code(q_code), .fb(fb_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level_valid <= 1'b0;
      level_code  <= MID_CODE;
    end else begin
      level_valid <= step;
      if (step) level_code <= force_mid ? MID_CODE : q_code;
    end
  end
endmodule

// File: rtl/dsm5_mod_chk.sv
module dsm5_mod_chk #(
  parameter int unsigned ACC_W = 22
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    force_mid,
  input logic                    sample_valid,
  input logic                    busy,
  input logic                    level_valid,
  input logic [2:0]              level_code,
  input logic signed [ACC_W-1:0] integ0,
  input logic signed [ACC_W-1:0] err
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!level_valid && level_code == 3'd2));

  // R3
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    level_valid |-> (level_code <= 3'd4));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !sample_valid) |=> !level_valid);

  // R7
  force_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (force_mid && busy) |=> (level_valid && level_code == 3'd2));

  // R6
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !force_mid && err > 0 && integ0 >= 0) |=> (integ0 >= $past(integ0)));

  // R6
  no_wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !force_mid && err < 0 && integ0 <= 0) |=> (integ0 <= $past(integ0)));
endmodule

bind dsm5_mod dsm5_mod_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .force_mid(force_mid), .sample_valid(sample_valid),
  .busy(step), .level_valid(level_valid), .level_code(level_code),
  .integ0(intg_q[0]), .err(err_acc)
);

// File: tb/dsm5_mod_test.sv
`timescale 1ns/1ps
module dsm5_mod_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] sample_in = '0;
  logic sample_valid = 1'b0;
  logic rate_sel = 1'b0;
  logic force_mid = 1'b0;
  logic [2:0] level_code;
  logic level_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  longint nout, fbsum, cyc, first_cyc, last_cyc;
  int bad_range, not_mid, not_zero, first_not4;

  always #2.5 clk = ~clk;

  dsm5_mod uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .sample_valid(sample_valid),
    .rate_sel(rate_sel), .force_mid(force_mid),
    .level_code(level_code), .level_valid(level_valid)
  );

  task automatic clr_mon();
    nout = 0; fbsum = 0; bad_range = 0; not_mid = 0; not_zero = 0;
    first_not4 = 0; first_cyc = -1; last_cyc = -1;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (level_valid) begin
      nout = nout + 1;
      fbsum = fbsum + (longint'(level_code) - 2);
      if (level_code > 3'd4) bad_range++;
      if (level_code != 3'd2) not_mid++;
      if (level_code != 3'd0) not_zero++;
      if (nout <= 64 && level_code != 3'd4) first_not4++;
      if (first_cyc < 0) first_cyc = cyc;
      last_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sample_valid = 1'b0; force_mid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clr_mon();
  endtask

  task automatic feed(input logic signed [17:0] val, input bit rs, input int nsamp);
    int hold;
    hold = rs ? 6 : 8;
    rate_sel = rs;
    for (int i = 0; i < nsamp; i++) begin
      sample_in = val; sample_valid = 1'b1;
      @(negedge clk);
      sample_valid = 1'b0;
      repeat (hold - 1) @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(level_valid == 1'b0, "R1 valid in reset", level_valid, 0);
    check(level_code == 3'd2, "R1 code in reset", level_code, 2);
    rst = 1'b0;
    clr_mon();
  endtask

  task automatic t_strobe_count();
    do_reset();
    feed(18'sd0, 1'b0, 1);
    check(nout == 8, "R2 strobes at slow rate", nout, 8);
    clr_mon();
    feed(18'sd0, 1'b1, 1);
    check(nout == 6, "R2 strobes at fast rate", nout, 6);
    clr_mon();
    repeat (20) @(negedge clk);
    check(nout == 0, "R2 no strobes when idle", nout, 0);
  endtask

  task automatic t_zero();
    do_reset();
    feed(18'sd0, 1'b1, 100);
    check(not_mid == 0, "R4 zero input gives code 2", not_mid, 0);
    check(nout == 600, "R2 count over zero run", nout, 600);
  endtask

  task automatic t_continuous(input bit rs);
    do_reset();
    feed(18'sd20000, rs, 200);
    check(last_cyc - first_cyc + 1 == nout, "R8 continuous strobes",
          last_cyc - first_cyc + 1, nout);
  endtask

  task automatic t_dc(input int val, input bit rs);
    longint diff;
    do_reset();
    feed(18'(val), rs, 512);
    diff = fbsum * 65536 - longint'(val) * nout;
    if (diff < 0) diff = -diff;
    check(bad_range == 0, "R3 code range", bad_range, 0);
    check(diff <= 524288, "R5 DC tracking error", diff, 524288);
  endtask

  task automatic t_fullscale();
    do_reset();
    feed(-18'sd131072, 1'b0, 50);
    check(not_zero == 0, "R6 negative full scale gives code 0", not_zero, 0);
    do_reset();
    feed(18'sd131071, 1'b0, 8);
    check(first_not4 == 0, "R6 positive full scale gives code 4", first_not4, 0);
    check(nout == 64, "R6 output count", nout, 64);
  endtask

  task automatic t_force();
    do_reset();
    feed(18'sd52429, 1'b0, 100);
    force_mid = 1'b1;
    clr_mon();
    feed(18'sd52429, 1'b0, 20);
    check(not_mid == 0, "R7 forced outputs are code 2", not_mid, 0);
    check(nout == 160, "R7 strobes continue while forced", nout, 160);
    force_mid = 1'b0;
    clr_mon();
    feed(18'sd0, 1'b0, 50);
    check(not_mid == 0, "R7 loop cleared after release", not_mid, 0);
  endtask

  initial begin
    cyc = 0;
    clr_mon();
    t_reset();
    t_strobe_count();
    t_zero();
    t_continuous(1'b0);
    t_continuous(1'b1);
    t_dc(52429, 1'b0);
    t_dc(-39322, 1'b1);
    t_fullscale();
    t_force();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule